// File: doc/BRIEF.md
# Run-Length Violation Detector

This block watches the parallel words that the receive path delivers once word alignment is done. It tracks how many equal bits in a row have been seen in the stream, counting a run of ones and a run of zeros the same way. Each accepted word is walked from its least significant bit upward, and a run does not stop at a word edge: it goes on into the next accepted word. When the current run grows longer than a programmed limit, a sticky violation flag is raised. The flag stays up until software pulses a clear or reset is applied.

The word width is picked at run time from 8, 10, 16 and 20 bits. The limit is given as a step count and not as a bit count. One step is half the selected word width, so 4, 5, 8 or 10 bits. The step count is clamped so that the limit never leaves the legal range for that width: 4..128, 5..160, 8..512 or 10..640 bits.

Top module: `runlen_guard`

## Requirements
- R1: When a bit of an accepted word makes the current run longer than the limit, `violation` is 1 on the first rising edge after that word. A run that only equals the limit leaves `violation` unchanged.
- R2: The bits of a word are taken in order from bit 0 upward. The run at the top active bit of one accepted word carries into bit 0 of the next accepted word.
- R3: A bit that differs from the one before it starts a new run of length one.
- R4: `widthSel` selects the active bits: 0 gives 8 bits, 1 gives 10, 2 gives 16 and 3 gives 20. Bits of `dataWord` above the active width have no effect.
- R5: The limit in bits is `threshSteps` times the step size. The step size is 4, 5, 8 and 10 for widthSel 0, 1, 2 and 3.
- R6: A `threshSteps` of 0 acts as 1. For widthSel 0 and 1, values above 32 act as 32. For widthSel 2 and 3, values above 64 act as 64.
- R7: `violation` stays 1 until `clearViol` is seen at a rising edge, and goes to 0 on that edge. If a violating word is accepted on the same edge, the flag stays 1.
- R8: While `dataValid` is 0, `dataWord` is ignored and the run state is kept. `violation` does not rise in such a cycle.
- R9: The run counter saturates at its top value and does not wrap. A run of any length stays a violation against every legal limit.
- R10: Reset, active low, clears `violation` and the run state. The first bit accepted after reset starts a run of length one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clearViol | input | 1 | Clears the sticky violation flag |
| dataValid | input | 1 | Accepts `dataWord` on this edge |
| dataWord | input | 20 | Received word, bit 0 is taken first |
| widthSel | input | 2 | Active word width: 0=8, 1=10, 2=16, 3=20 |
| threshSteps | input | 7 | Run limit, counted in steps of half the word width |
| violation | output | 1 | Sticky run-length violation flag |

## Verification
The case that is hardest to reach from the ports is counter saturation. The run has to be longer than the counter can hold, and this can only be seen through a fresh violation after a clear. The bench therefore sends more than a thousand equal bits as 20-bit words against the largest limit. It then clears the flag and sends one more equal word, so that a wrapped counter would stay quiet while a saturated one raises the flag again. Runs that cross word edges and runs that land exactly on the limit come from directed words. Biased random words, mostly all-ones, all-zeros or sparse, produce long runs at every width.

// File: rtl/runlen_pkg.sv
package runlen_pkg;

  // Widest supported word and the counter/step field sizes
  localparam int LANES      = 20;
  localparam int CNT_BITS   = 10;
  localparam int STEP_BITS  = 7;
  localparam int LANE_IDX_W = $clog2(LANES + 1);

  // Step caps for the narrow and wide width groups
  localparam int STEP_CAP_NARROW = 32;
  localparam int STEP_CAP_WIDE   = 64;

  typedef enum logic [1:0] {
    WSEL_8  = 2'd0,
    WSEL_10 = 2'd1,
    WSEL_16 = 2'd2,
    WSEL_20 = 2'd3
  } widthSel_e;

  // Strobes and settings passed from control to datapath
  typedef struct packed {
    logic                advance;
    logic                dropFlag;
    logic [LANES-1:0]    laneMask;
    logic [CNT_BITS-1:0] limit;
  } rlStrobe_t;

  function automatic logic [CNT_BITS-1:0] satInc(input logic [CNT_BITS-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

endpackage

// File: rtl/runlen_ctrl.sv
module runlen_ctrl
  import runlen_pkg::*;
(
  input  logic                 dataValid,
  input  logic                 clearViol,
  input  logic [1:0]           widthSel,
  input  logic [STEP_BITS-1:0] threshSteps,
  output rlStrobe_t            strb
);

  logic [LANE_IDX_W-1:0] activeLanes;
  logic [LANE_IDX_W-1:0] stepSize;
  logic [STEP_BITS-1:0]  stepCap;
  logic [STEP_BITS-1:0]  stepsKept;
  logic [LANES-1:0]      laneMask;

  // Width decode
  always_comb begin
    unique case (widthSel_e'(widthSel))
      WSEL_8:  activeLanes = LANE_IDX_W'(8);
      WSEL_10: activeLanes = LANE_IDX_W'(10);
      WSEL_16: activeLanes = LANE_IDX_W'(16);
      default: activeLanes = LANE_IDX_W'(20);
    endcase
  end

  assign stepSize = activeLanes >> 1;
  assign stepCap  = widthSel[1] ? STEP_BITS'(STEP_CAP_WIDE) : STEP_BITS'(STEP_CAP_NARROW);

  // Clamp the step count into the legal window
  always_comb begin
    if (threshSteps == '0)          stepsKept = STEP_BITS'(1);
    else if (threshSteps > stepCap) stepsKept = stepCap;
    else                            stepsKept = threshSteps;
  end

  // One enable per bit lane
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneMask[i] = (LANE_IDX_W'(i) < activeLanes);
  end

  always_comb begin
    strb.advance  = dataValid;
    strb.dropFlag = clearViol;
    strb.laneMask = laneMask;
    strb.limit    = CNT_BITS'(stepsKept) * CNT_BITS'(stepSize);
  end

endmodule

// File: rtl/runlen_walk.sv
module runlen_walk
  import runlen_pkg::*;
(
  input  logic [CNT_BITS-1:0] startCount,
  input  logic                startBit,
  input  logic [LANES-1:0]    dataWord,
  input  logic [LANES-1:0]    laneMask,
  input  logic [CNT_BITS-1:0] limit,
  output logic [CNT_BITS-1:0] endCount,
  output logic                endBit,
  output logic                wordHit
);

  logic [CNT_BITS-1:0] walkCount;
  logic                walkBit;

  // Bit-serial walk over the word, bit 0 first
  always_comb begin
    walkCount = startCount;
    walkBit   = startBit;
    wordHit   = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (laneMask[i]) begin
        if ((walkCount != '0) && (dataWord[i] == walkBit)) walkCount = satInc(walkCount);
        else                                               walkCount = CNT_BITS'(1);
        walkBit = dataWord[i];
        if (walkCount > limit) wordHit = 1'b1;
      end
    end
    endCount = walkCount;
    endBit   = walkBit;
  end

endmodule

// File: rtl/runlen_datapath.sv
module runlen_datapath
  import runlen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  rlStrobe_t        strb,
  input  logic [LANES-1:0] dataWord,
  output logic             violation
);

  logic [CNT_BITS-1:0] runCount;
  logic                lastBit;
  logic [CNT_BITS-1:0] nextCount;
  logic                nextBit;
  logic                wordHit;

  runlen_walk u_walk (
    .startCount (runCount),
    .startBit   (lastBit),
    .dataWord   (dataWord),
    .laneMask   (strb.laneMask),
    .limit      (strb.limit),
    .endCount   (nextCount),
    .endBit     (nextBit),
    .wordHit    (wordHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
      lastBit  <= 1'b0;
    end else if (strb.advance) begin
      runCount <= nextCount;
      lastBit  <= nextBit;
    end
  end

  // Sticky flag: a new hit wins over a clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          violation <= 1'b0;
    else if (strb.advance && wordHit)   violation <= 1'b1;
    else if (strb.dropFlag)             violation <= 1'b0;
  end

endmodule

// File: rtl/runlen_guard.sv
module runlen_guard
  import runlen_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clearViol,
  input  logic                 dataValid,
  input  logic [LANES-1:0]     dataWord,
  input  logic [1:0]           widthSel,
  input  logic [STEP_BITS-1:0] threshSteps,
  output logic                 violation
);

  rlStrobe_t strb;

  runlen_ctrl u_ctrl (
    .dataValid   (dataValid),
    .clearViol   (clearViol),
    .widthSel    (widthSel),
    .threshSteps (threshSteps),
    .strb        (strb)
  );

  runlen_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dataWord  (dataWord),
    .violation (violation)
  );

endmodule

// File: rtl/runlen_guard_chk.sv
module runlen_guard_chk
  import runlen_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       clearViol,
  input logic       dataValid,
  input logic [1:0] widthSel,
  input logic       violation,
  input rlStrobe_t  strb
);

  logic [CNT_BITS-1:0] minLimit;
  logic [CNT_BITS-1:0] maxLimit;

  always_comb begin
    case (widthSel)
      2'd0:    begin minLimit = CNT_BITS'(4);  maxLimit = CNT_BITS'(128); end
      2'd1:    begin minLimit = CNT_BITS'(5);  maxLimit = CNT_BITS'(160); end
      2'd2:    begin minLimit = CNT_BITS'(8);  maxLimit = CNT_BITS'(512); end
      default: begin minLimit = CNT_BITS'(10); maxLimit = CNT_BITS'(640); end
    endcase
  end

  // R6: limit always inside the legal window for the width
  p_limit_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.limit >= minLimit) && (strb.limit <= maxLimit));

  // R7: flag holds while no clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    violation && !clearViol |=> violation);

  // R7: clear without a new word drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    clearViol && !dataValid |=> !violation);

  // R8: idle cycles never raise the flag
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid && !violation |=> !violation);

  // R1: a rise is always caused by an accepted word
  p_rise_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |-> $past(dataValid));

endmodule

bind runlen_guard runlen_guard_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clearViol (clearViol),
  .dataValid (dataValid),
  .widthSel  (widthSel),
  .violation (violation),
  .strb      (strb)
);

// File: tb/runlen_guard_tb.sv
module runlen_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearViol = 1'b0;
  logic        dataValid = 1'b0;
  logic [19:0] dataWord = '0;
  logic [1:0]  widthSel = '0;
  logic [6:0]  threshSteps = 7'd1;
  logic        violation;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // Reference model state
  int mCount = 0;
  bit mBit = 0;
  bit mFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  runlen_guard u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .clearViol   (clearViol),
    .dataValid   (dataValid),
    .dataWord    (dataWord),
    .widthSel    (widthSel),
    .threshSteps (threshSteps),
    .violation   (violation)
  );

  function automatic int widthOf(input logic [1:0] w);
    case (w)
      2'd0: return 8;
      2'd1: return 10;
      2'd2: return 16;
      default: return 20;
    endcase
  endfunction

  function automatic int limitOf(input logic [1:0] w, input int steps);
    int cap = (w >= 2) ? 64 : 32;
    int s = steps;
    if (s < 1) s = 1;
    if (s > cap) s = cap;
    return s * (widthOf(w) / 2);
  endfunction

  task automatic modelStep(input bit v, input bit clr, input logic [19:0] d,
                           input logic [1:0] w, input int steps);
    bit hit = 0;
    if (v) begin
      for (int i = 0; i < widthOf(w); i++) begin
        if (mCount > 0 && d[i] == mBit) mCount++;
        else mCount = 1;
        mBit = d[i];
        if (mCount > limitOf(w, steps)) hit = 1;
      end
    end
    if (hit) mFlag = 1;
    else if (clr) mFlag = 0;
  endtask

  task automatic check(input string req);
    testsRun++;
    if (violation !== mFlag) begin
      testsFailed++;
      $display("FAIL %s: violation=%0b expected=%0b", req, violation, mFlag);
    end
  endtask

  // Drive at falling edge, model at rising edge, compare at next falling edge
  task automatic cycle(input bit v, input bit clr, input logic [19:0] d,
                       input logic [1:0] w, input int steps, input string req);
    dataValid = v; clearViol = clr; dataWord = d; widthSel = w; threshSteps = 7'(steps);
    @(posedge clk);
    modelStep(v, clr, d, w, steps);
    @(negedge clk);
    dataValid = 0; clearViol = 0;
    check(req);
  endtask

  task automatic doReset();
    rstN = 0;
    mCount = 0; mBit = 0; mFlag = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1d2c3b4a;
    void'($urandom(seed));
    @(negedge clk);
    doReset();
    check("R10 reset state");

    // R1/R5: width 8, one step -> limit 4; LSB-first runs of exactly 4
    cycle(1, 0, 20'h0000F, 2'd0, 1, "R1 run equals limit");
    // R2: top bits 0000 continue into next word bits 0..: 0 makes run 5
    cycle(1, 0, 20'h000FE, 2'd0, 1, "R2 run carries across word edge");
    cycle(1, 1, 20'h00000, 2'd0, 0, "R7 hit wins over clear");
    cycle(0, 1, 20'hFFFFF, 2'd0, 1, "R7 clear drops flag");
    cycle(1, 0, 20'h00055, 2'd0, 1, "R3 alternating restarts run");
    cycle(1, 0, 20'hFFF55, 2'd0, 1, "R4 bits above width ignored");
    cycle(0, 0, 20'h00000, 2'd0, 1, "R8 idle word ignored");
    cycle(0, 0, 20'h00000, 2'd0, 1, "R8 idle keeps flag low");

    // R5/R6: width 20, step 2 -> limit 20
    doReset();
    cycle(1, 0, 20'hFFFFF, 2'd3, 2, "R5 full word equals limit");
    cycle(1, 0, 20'h00001, 2'd3, 2, "R5 one more bit over limit");
    cycle(0, 1, 20'h0, 2'd3, 2, "R7 clear");
    // steps 0 acts as 1 -> limit 8 at width 16
    cycle(1, 0, 20'h001FF, 2'd2, 0, "R6 zero steps acts as one");
    cycle(0, 1, 20'h0, 2'd2, 0, "R7 clear");
    // steps 127 at width 10 -> 32 steps, limit 160
    doReset();
    for (int k = 0; k < 16; k++) cycle(1, 0, 20'h003FF, 2'd1, 127, "R6 clamp narrow at limit");
    cycle(1, 0, 20'h00001, 2'd1, 127, "R6 clamp narrow one over");

    // R9: saturation, width 20, limit 640
    doReset();
    for (int k = 0; k < 56; k++) cycle(1, 0, 20'hFFFFF, 2'd3, 127, "R9 long run");
    cycle(0, 1, 20'h0, 2'd3, 127, "R9 clear during long run");
    cycle(1, 0, 20'hFFFFF, 2'd3, 127, "R9 saturated run still violates");

    // Biased random phase
    doReset();
    for (int n = 0; n < 3000; n++) begin
      logic [19:0] d;
      int pick = $urandom_range(0, 9);
      logic [1:0] w = 2'($urandom_range(0, 3));
      int st = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 127) : $urandom_range(0, 4);
      bit v = ($urandom_range(0, 9) != 0);
      bit clr = ($urandom_range(0, 7) == 0);
      case (pick)
        0, 1, 2: d = 20'hFFFFF;
        3, 4, 5: d = 20'h00000;
        6:       d = 20'($urandom) & 20'($urandom);
        default: d = 20'($urandom);
      endcase
      cycle(v, clr, d, w, st, "R1 R2 R3 R4 R5 R7 R8 random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule